// File: doc/BRIEF.md
# Software Flow Control Engine

This block handles character-based (XON/XOFF) flow control for one serial channel. It sits beside the receiver, the transmitter and the receive FIFO. For every character the receiver decodes, it checks whether the character matches one of two programmable control codes. On a match it records an interrupt status flag. It can also stop the transmitter from starting new characters, and it can remove the character from the stream going into the FIFO.

When automatic receive pacing is enabled, the block watches the receive FIFO fill level. It asks the transmitter to send the stop code when the FIFO becomes nearly full. It asks for the resume code once the FIFO has drained. When both automatic modes are off, the host may request either code directly.

A request to send a code is held until the transmitter accepts it. The code is latched when the request is made. Transmit gating is updated only while no character is in flight. Serialization, baud timing and the FIFOs themselves are outside the block.

Top module: `swflow_ctrl`

## Requirements
- R1: After reset the resume code is 0x11 and the stop code is 0x13. After reset `sendReq` is 0, `txAllow` is 1, `flowStat` is 0 and `flowIrq` is 0.
- R2: `modeSel` bit 0 enables automatic transmit gating and bit 1 enables automatic receive pacing. The value 00 is host-only, 01 is transmit gating only, 10 is receive pacing only and 11 is both. With bit 0 clear, received codes never lower `txAllow`.
- R3: With `modeSel[0]`=1, a received stop code lowers `txAllow` and a received resume code raises it again. The change appears two clock edges after the strobe edge when `txBusy` is low. If the same character matches both codes, the stop code wins.
- R4: While `txBusy` is high at a clock edge, `txAllow` does not change at that edge. A character already in flight therefore finishes first.
- R5: With `modeSel[1]`=1 and pacing not already asserted, a fill level of 12 or more issues exactly one stop-code request. No further stop request follows while the level stays high.
- R6: Once a stop code has been requested by pacing, a fill level of 8 or less issues exactly one resume-code request.
- R7: Host requests take effect only when `modeSel` is 00. In that case a stop request has priority over a resume request made in the same cycle. For any other `modeSel` value, host requests are ignored.
- R8: `sendReq` stays high with a stable `sendCode` until a cycle in which `sendAck` is high. It falls at that edge. While a request is pending, no new request is taken.
- R9: `pushOk` is combinational. It equals `rxValid`, except that it is 0 when `stripEn` is 1 and the character matches either code. Stripping works the same way in every mode.
- R10: `flowStat` is set by any received code, whatever the mode. It is cleared by `statusRd`. If a code arrives in the same cycle as `statusRd`, the set wins.
- R11: `flowIrq` is `flowStat` qualified by `irqMask`.
- R12: `codeWrXon` and `codeWrXoff` load `codeWrData` into the resume and stop code registers respectively. Matching then uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | Automatic mode select (bit 0 transmit gating, bit 1 receive pacing) |
| stripEn | input | 1 | Remove matched codes from the FIFO stream |
| irqMask | input | 1 | Interrupt enable for the flow status |
| codeWrXon | input | 1 | Write strobe for the resume code |
| codeWrXoff | input | 1 | Write strobe for the stop code |
| codeWrData | input | CHAR_W | Code write data |
| rxValid | input | 1 | Receiver decoded-character strobe |
| rxChar | input | CHAR_W | Decoded character |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| hostXonReq | input | 1 | Host request to send the resume code |
| hostXoffReq | input | 1 | Host request to send the stop code |
| sendAck | input | 1 | Transmitter accepts the pending code |
| txBusy | input | 1 | Transmitter is shifting a character |
| statusRd | input | 1 | Host read of the flow status (clears it) |
| txAllow | output | 1 | Transmitter may start a new data character |
| sendReq | output | 1 | Request to transmit a control code |
| sendCode | output | CHAR_W | Code to transmit |
| pushOk | output | 1 | Qualified FIFO push strobe |
| flowStat | output | 1 | Raw flow-character status |
| flowIrq | output | 1 | Masked flow-character interrupt |

## Verification
The receipt of a matching code and a host status read can fall in the same clock cycle. The code's set must win over the read's clear. The bench provokes this directly: it strobes a resume code with `statusRd` high in one cycle and expects `flowStat` to read 1 afterwards. The random phase then drives both signals independently at moderate rates, so they collide repeatedly in every mode. Each collision is judged against a bench model in which the set has priority.

// File: rtl/swflow_pkg.sv
package swflow_pkg;

  // events decoded by the datapath for the control
  typedef struct packed {
    logic gotXon;
    logic gotXoff;
    logic fillHigh;
    logic fillLow;
  } dp_evt_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadReq;
    logic loadXoff;
  } ctl_cmd_t;

endpackage

// File: rtl/swflow_dp.sv
module swflow_dp
  import swflow_pkg::*;
#(
  parameter int CHAR_W    = 8,
  parameter int LVL_W     = 6,
  parameter int HI_MARK   = 12,
  parameter int LO_MARK   = 8,
  parameter logic [CHAR_W-1:0] XON_INIT  = 8'h11,
  parameter logic [CHAR_W-1:0] XOFF_INIT = 8'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              codeWrXon,
  input  logic              codeWrXoff,
  input  logic [CHAR_W-1:0] codeWrData,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              stripEn,
  input  ctl_cmd_t          cmd,
  output dp_evt_t           evt,
  output logic [CHAR_W-1:0] sendCode,
  output logic              pushOk
);

  localparam logic [LVL_W-1:0] HI_LVL = LVL_W'(HI_MARK);
  localparam logic [LVL_W-1:0] LO_LVL = LVL_W'(LO_MARK);

  logic [CHAR_W-1:0] xonQ, xoffQ, sendCodeQ;
  logic matchXon, matchXoff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xonQ  <= XON_INIT;
      xoffQ <= XOFF_INIT;
    end else begin
      if (codeWrXon)  xonQ  <= codeWrData;
      if (codeWrXoff) xoffQ <= codeWrData;
    end
  end

  assign matchXon  = rxValid && (rxChar == xonQ);
  assign matchXoff = rxValid && (rxChar == xoffQ);

  always_comb begin
    evt.gotXon   = matchXon;
    evt.gotXoff  = matchXoff;
    evt.fillHigh = (rxLevel >= HI_LVL);
    evt.fillLow  = (rxLevel <= LO_LVL);
  end

  // code is frozen when the request is raised
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sendCodeQ <= '0;
    else if (cmd.loadReq) sendCodeQ <= cmd.loadXoff ? xoffQ : xonQ;
  end

  assign sendCode = sendCodeQ;
  assign pushOk   = rxValid && !(stripEn && (matchXon || matchXoff));

endmodule

// File: rtl/swflow_fsm.sv
module swflow_fsm
  import swflow_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  dp_evt_t    evt,
  input  logic       hostXonReq,
  input  logic       hostXoffReq,
  input  logic       sendAck,
  input  logic       txBusy,
  input  logic       statusRd,
  input  logic       irqMask,
  output ctl_cmd_t   cmd,
  output logic       sendReq,
  output logic       txAllow,
  output logic       flowStat,
  output logic       flowIrq
);

  logic autoTx, autoRx, hostOnly;
  logic haltQ, allowQ, pendQ, thrQ, statQ;
  logic pendD, thrD;

  assign autoTx   = modeSel[0];
  assign autoRx   = modeSel[1];
  assign hostOnly = (modeSel == 2'b00);

  always_comb begin
    cmd   = '0;
    thrD  = thrQ;
    pendD = pendQ && !sendAck;
    if (!pendQ) begin
      if (autoRx) begin
        if (!thrQ && evt.fillHigh) begin
          cmd.loadReq  = 1'b1;
          cmd.loadXoff = 1'b1;
          thrD         = 1'b1;
        end else if (thrQ && evt.fillLow) begin
          cmd.loadReq = 1'b1;
          thrD        = 1'b0;
        end
      end else if (hostOnly) begin
        if (hostXoffReq) begin
          cmd.loadReq  = 1'b1;
          cmd.loadXoff = 1'b1;
        end else if (hostXonReq) begin
          cmd.loadReq = 1'b1;
        end
      end
    end
    if (!autoRx) thrD = 1'b0;
    if (cmd.loadReq) pendD = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ  <= 1'b0;
      allowQ <= 1'b1;
      pendQ  <= 1'b0;
      thrQ   <= 1'b0;
      statQ  <= 1'b0;
    end else begin
      if (!autoTx)          haltQ <= 1'b0;
      else if (evt.gotXoff) haltQ <= 1'b1;
      else if (evt.gotXon)  haltQ <= 1'b0;
      if (!txBusy) allowQ <= !haltQ;
      pendQ <= pendD;
      thrQ  <= thrD;
      if (evt.gotXon || evt.gotXoff) statQ <= 1'b1;
      else if (statusRd)             statQ <= 1'b0;
    end
  end

  assign sendReq  = pendQ;
  assign txAllow  = allowQ;
  assign flowStat = statQ;
  assign flowIrq  = statQ && irqMask;

endmodule

// File: rtl/swflow_ctrl.sv
module swflow_ctrl
  import swflow_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int LVL_W   = 6,
  parameter int HI_MARK = 12,
  parameter int LO_MARK = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              stripEn,
  input  logic              irqMask,
  input  logic              codeWrXon,
  input  logic              codeWrXoff,
  input  logic [CHAR_W-1:0] codeWrData,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic              hostXonReq,
  input  logic              hostXoffReq,
  input  logic              sendAck,
  input  logic              txBusy,
  input  logic              statusRd,
  output logic              txAllow,
  output logic              sendReq,
  output logic [CHAR_W-1:0] sendCode,
  output logic              pushOk,
  output logic              flowStat,
  output logic              flowIrq
);

  dp_evt_t  evt;
  ctl_cmd_t cmd;

  swflow_dp #(
    .CHAR_W(CHAR_W), .LVL_W(LVL_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .codeWrXon(codeWrXon), .codeWrXoff(codeWrXoff), .codeWrData(codeWrData),
    .rxValid(rxValid), .rxChar(rxChar), .rxLevel(rxLevel), .stripEn(stripEn),
    .cmd(cmd), .evt(evt), .sendCode(sendCode), .pushOk(pushOk)
  );

  swflow_fsm u_fsm (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .evt(evt),
    .hostXonReq(hostXonReq), .hostXoffReq(hostXoffReq),
    .sendAck(sendAck), .txBusy(txBusy), .statusRd(statusRd), .irqMask(irqMask),
    .cmd(cmd), .sendReq(sendReq), .txAllow(txAllow),
    .flowStat(flowStat), .flowIrq(flowIrq)
  );

endmodule

// File: rtl/swflow_chk.sv
module swflow_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              stripEn,
  input logic              rxValid,
  input logic              sendAck,
  input logic              txBusy,
  input logic              statusRd,
  input logic              txAllow,
  input logic              sendReq,
  input logic [CHAR_W-1:0] sendCode,
  input logic              pushOk,
  input logic              flowStat
);

  // R4: gating frozen across an edge where a character is in flight
  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(txBusy) |-> $stable(txAllow));

  // R7: transmit-gating-only mode never raises a request
  p_host_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01 && !sendReq) |=> !sendReq);

  // R8: request and its code held until accepted
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && !sendAck) |=> (sendReq && $stable(sendCode)));

  // R9: no push without a character; no strip when stripping is off
  p_push_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    pushOk |-> rxValid);
  p_no_strip_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !stripEn) |-> pushOk);

  // R10: a stripped character is a code and sets the status
  p_stat_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !pushOk) |=> flowStat);
  p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !rxValid) |=> !flowStat);

endmodule

bind swflow_ctrl swflow_chk #(.CHAR_W(CHAR_W)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .stripEn(stripEn),
  .rxValid(rxValid), .sendAck(sendAck), .txBusy(txBusy), .statusRd(statusRd),
  .txAllow(txAllow), .sendReq(sendReq), .sendCode(sendCode),
  .pushOk(pushOk), .flowStat(flowStat)
);

// File: tb/sim_swflow_ctrl.sv
module sim_swflow_ctrl;

  localparam int CHAR_W = 8;
  localparam int LVL_W  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = '0;
  logic stripEn = 0, irqMask = 0, codeWrXon = 0, codeWrXoff = 0;
  logic [CHAR_W-1:0] codeWrData = '0, rxChar = '0;
  logic rxValid = 0, hostXonReq = 0, hostXoffReq = 0, sendAck = 0;
  logic txBusy = 0, statusRd = 0;
  logic [LVL_W-1:0] rxLevel = '0;
  logic txAllow, sendReq, pushOk, flowStat, flowIrq;
  logic [CHAR_W-1:0] sendCode;

  int checks = 0, errors = 0;
  bit doneRun = 0;

  // bench model
  logic [7:0] mXon = 8'h11, mXoff = 8'h13, mCode = '0;
  logic mHalt = 0, mAllow = 1, mPend = 0, mThr = 0, mStat = 0;

  always #10 clk = ~clk;

  swflow_ctrl #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .stripEn(stripEn),
    .irqMask(irqMask), .codeWrXon(codeWrXon), .codeWrXoff(codeWrXoff),
    .codeWrData(codeWrData), .rxValid(rxValid), .rxChar(rxChar),
    .rxLevel(rxLevel), .hostXonReq(hostXonReq), .hostXoffReq(hostXoffReq),
    .sendAck(sendAck), .txBusy(txBusy), .statusRd(statusRd),
    .txAllow(txAllow), .sendReq(sendReq), .sendCode(sendCode),
    .pushOk(pushOk), .flowStat(flowStat), .flowIrq(flowIrq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expPush(input logic v, input logic [7:0] c, input logic s);
    return v && !(s && (c == mXon || c == mXoff));
  endfunction

  // one clock: check comb push, advance model, compare registered outputs
  task automatic tick();
    logic fx, fn;
    logic nHalt, nAllow, nPend, nThr, nStat;
    logic [7:0] nCode, nXon, nXoff;
    #1;
    chk("R9 pushOk", pushOk, expPush(rxValid, rxChar, stripEn));
    fx = rxValid && rxChar == mXoff;
    fn = rxValid && rxChar == mXon;
    nHalt  = !modeSel[0] ? 1'b0 : fx ? 1'b1 : fn ? 1'b0 : mHalt;
    nAllow = txBusy ? mAllow : !mHalt;
    nPend  = mPend && !sendAck;
    nThr   = mThr;
    nCode  = mCode;
    if (!mPend) begin
      if (modeSel[1]) begin
        if (!mThr && rxLevel >= 12) begin nPend = 1; nCode = mXoff; nThr = 1; end
        else if (mThr && rxLevel <= 8) begin nPend = 1; nCode = mXon; nThr = 0; end
      end else if (modeSel == 2'b00) begin
        if (hostXoffReq) begin nPend = 1; nCode = mXoff; end
        else if (hostXonReq) begin nPend = 1; nCode = mXon; end
      end
    end
    if (!modeSel[1]) nThr = 0;
    nStat = (fx || fn) ? 1'b1 : statusRd ? 1'b0 : mStat;
    nXon  = codeWrXon  ? codeWrData : mXon;
    nXoff = codeWrXoff ? codeWrData : mXoff;
    @(posedge clk);
    mHalt = nHalt; mAllow = nAllow; mPend = nPend; mThr = nThr; mCode = nCode;
    mStat = nStat; mXon = nXon; mXoff = nXoff;
    @(negedge clk);
    chk("R8 sendReq", sendReq, mPend);
    if (mPend) chk("R8 sendCode", sendCode, mCode);
    chk("R3 txAllow", txAllow, mAllow);
    chk("R10 flowStat", flowStat, mStat);
    chk("R11 flowIrq", flowIrq, mStat && irqMask);
  endtask

  initial begin
    #(200000 * 20);
    if (!doneRun) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 sendReq", sendReq, 0);
    chk("R1 txAllow", txAllow, 1);
    chk("R1 flowStat", flowStat, 0);
    chk("R1 flowIrq", flowIrq, 0);

    // R1/R9/R3/R10: default stop code, stripped, gates tx
    modeSel = 2'b01; stripEn = 1; irqMask = 1; rxValid = 1; rxChar = 8'h13;
    #1 chk("R1 default stop code stripped", pushOk, 0);
    tick();
    rxValid = 0;
    chk("R10 set on code", flowStat, 1);
    chk("R11 masked irq on", flowIrq, 1);
    tick();
    chk("R3 stop lowers txAllow", txAllow, 0);

    // R4 in-flight character holds gating
    txBusy = 1; rxValid = 1; rxChar = 8'h11;
    tick();
    rxValid = 0;
    tick(); tick();
    chk("R4 held while busy", txAllow, 0);
    txBusy = 0;
    tick();
    chk("R3 resume raises txAllow", txAllow, 1);

    // R10 clear on read
    statusRd = 1; tick(); statusRd = 0;
    chk("R10 clear on read", flowStat, 0);

    // R5/R6/R8 receive pacing
    modeSel = 2'b10; rxLevel = 12;
    tick();
    chk("R5 stop request", sendReq, 1);
    chk("R5 stop code", sendCode, 8'h13);
    tick();
    chk("R8 held without ack", sendReq, 1);
    sendAck = 1; tick(); sendAck = 0;
    chk("R8 cleared by ack", sendReq, 0);
    rxLevel = 15; tick(); tick();
    chk("R5 only once", sendReq, 0);
    rxLevel = 9; tick();
    chk("R6 not yet at 9", sendReq, 0);
    rxLevel = 8; tick();
    chk("R6 resume request", sendReq, 1);
    chk("R6 resume code", sendCode, 8'h11);
    sendAck = 1; tick(); sendAck = 0;
    rxLevel = 5; tick();
    chk("R6 only once", sendReq, 0);

    // R7 host commands
    modeSel = 2'b01; hostXoffReq = 1; tick();
    chk("R7 ignored when not 00", sendReq, 0);
    modeSel = 2'b11; hostXoffReq = 0; hostXonReq = 1; tick();
    chk("R7 ignored in mode 11", sendReq, 0);
    modeSel = 2'b00; hostXoffReq = 1; hostXonReq = 1; tick();
    chk("R7 host request taken", sendReq, 1);
    chk("R7 stop has priority", sendCode, 8'h13);
    hostXoffReq = 0; hostXonReq = 0; sendAck = 1; tick(); sendAck = 0;

    // R10 collision: code and read in one cycle
    rxValid = 1; rxChar = 8'h11; statusRd = 1; tick();
    chk("R10 set wins over read", flowStat, 1);
    rxValid = 0; statusRd = 0; irqMask = 0; tick();
    chk("R11 masked off", flowIrq, 0);
    irqMask = 1;
    #1 chk("R11 unmasked", flowIrq, 1);
    statusRd = 1; tick(); statusRd = 0;

    // R12 code reprogramming
    codeWrXoff = 1; codeWrData = 8'h55; tick(); codeWrXoff = 0;
    rxValid = 1; rxChar = 8'h55;
    #1 chk("R12 new stop code stripped", pushOk, 0);
    tick();
    rxChar = 8'h13;
    #1 chk("R12 old code passes", pushOk, 1);
    tick();
    rxValid = 0;

    // R9 strip off
    stripEn = 0; rxValid = 1; rxChar = 8'h55;
    #1 chk("R9 code pushed when strip off", pushOk, 1);
    tick(); rxValid = 0;

    // R2 receive-only mode does not gate tx
    modeSel = 2'b10; rxValid = 1; rxChar = 8'h55; tick();
    rxValid = 0; tick(); tick();
    chk("R2 no gating in mode 10", txAllow, 1);
    sendAck = 1; tick(); sendAck = 0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      if (($urandom % 50) == 0) modeSel = 2'($urandom);
      if (($urandom % 40) == 0) stripEn = ~stripEn;
      irqMask = ($urandom % 4) != 0;
      codeWrXon  = ($urandom % 200) == 0;
      codeWrXoff = ($urandom % 200) == 0;
      codeWrData = 8'($urandom);
      rxValid = ($urandom % 3) == 0;
      r = $urandom % 4;
      rxChar = (r == 0) ? mXon : (r == 1) ? mXoff : 8'($urandom);
      rxLevel = LVL_W'($urandom % 21);
      hostXonReq  = ($urandom % 8) == 0;
      hostXoffReq = ($urandom % 8) == 0;
      sendAck  = ($urandom % 2) == 0;
      txBusy   = ($urandom % 3) == 0;
      statusRd = ($urandom % 4) == 0;
      tick();
    end

    doneRun = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule